// File: doc/BRIEF.md
# Gated SPI Mode-0 Target Front End

This block is the serial front end of a small nonvolatile register device. It oversamples the SPI pins with the system clock and shifts in command, address and data bytes most significant bit first. It presents each completed byte on a parallel port with a one-cycle strobe, and it shifts out a parallel read byte on the serial output. The serial output enable is driven only while a transfer has been accepted.

Two gates sit in front of the byte strobes. A supervisor's inhibit input abandons any transfer in progress. After an inhibit, or after reset, nothing is accepted until the chip select shows a fresh falling edge. A write-protect pin suppresses the write strobe that follows a write opcode, while reads and the plain byte strobes continue.

Top module: `spi_target_gate`

## Requirements
- R1: Each bit on `si_i` is sampled at a rising edge of `sck_i`, and `rx_byte_o` holds the eight bits of a byte with the first-sent bit in bit 7.
- R2: `rx_valid_o` is high for exactly one system clock after every eighth captured bit. `rx_first_o` is high with it only for the first byte after the chip select falls.
- R3: On acceptance, `tx_byte_i` is loaded and its bit 7 is on `so_o` before the first rising edge of `sck_i`. The next bit appears after each falling edge. At every byte boundary `tx_byte_i` is reloaded, and its bit 7 is shown before the following rising edge.
- R4: `so_oe_o` is low while `csn_i` is high and whenever no transfer is accepted.
- R5: A chip select that is already low when reset is released is ignored: no strobe and no output enable until `csn_i` goes high and then low again.
- R6: When the first byte equals parameter `WR_OPC` (default 8'h02) and `wp_n_i` is high, every later byte of the same transfer raises `wr_stb_o` together with `rx_valid_o`.
- R7: While `wp_n_i` is low, `wr_stb_o` stays low and `rx_valid_o` still pulses for every byte.
- R8: While `inhibit_i` is high, the transfer is dropped and `so_oe_o` falls. Afterwards no strobe is issued until a new falling edge of `csn_i`.
- R9: A rising edge of `csn_i` clears the bit count, so a partial byte is discarded and the next transfer starts on a byte boundary.
- R10: A first byte other than `WR_OPC` produces no `wr_stb_o` for the rest of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, idles low |
| csn_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| inhibit_i | input | 1 | Supervisor inhibit, active high |
| wp_n_i | input | 1 | Write protect, low blocks write strobes |
| tx_byte_i | input | 8 | Byte to be shifted out next |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | Byte-received strobe |
| rx_first_o | output | 1 | Marks the opcode byte |
| wr_stb_o | output | 1 | Write-data strobe |

## Verification
The eighth rising serial edge completes a received byte. In the same system cycle it reloads the transmit shifter with the next read byte. The falling edge that follows must then leave the new bit 7 in place instead of shifting. Multi-byte read transfers provoke this on every boundary. The bench compares each bit on `so_o` just before every rising edge against the byte it supplied, so a lost or doubled bit at the boundary shows up as a mismatch in the second byte.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic              active;
        logic [2:0]        cnt;
        logic [BYTE_W-1:0] rx_sh;
        logic [BYTE_W-1:0] tx_sh;
        logic              first;
        logic              wr_cmd;
        logic [BYTE_W-1:0] rx_byte;
        logic              rx_valid;
        logic              rx_first;
        logic              wr_stb;
    } core_state_t;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] chain_q [STAGES];
    logic [N-1:0] chain_d [STAGES];
    logic [N-1:0] prev_q, prev_d;

    always_comb begin
        chain_d[0] = pin_i;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
        prev_d = chain_q[STAGES-1];
    end

    // reset to low: a chip select already low at release yields no falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
            prev_q <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
            prev_q <= prev_d;
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spi_tgt_core.sv
module spi_tgt_core
    import spi_tgt_pkg::*;
#(
    parameter logic [BYTE_W-1:0] WR_OPC = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              cs_rise_i,
    input  logic              cs_fall_i,
    input  logic              si_i,
    input  logic              inhibit_i,
    input  logic              wp_n_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              rx_first_o,
    output logic              wr_stb_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    core_state_t s_q, s_d;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        s_d = s_q;
        s_d.rx_valid = 1'b0;
        s_d.rx_first = 1'b0;
        s_d.wr_stb   = 1'b0;
        shifted = {s_q.rx_sh[BYTE_W-2:0], si_i};
        if (inhibit_i) begin
            s_d.active = 1'b0;
            s_d.cnt    = '0;
            s_d.wr_cmd = 1'b0;
        end else if (cs_rise_i) begin
            s_d.active = 1'b0;
            s_d.cnt    = '0;
        end else if (cs_fall_i) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.first  = 1'b1;
            s_d.wr_cmd = 1'b0;
            s_d.tx_sh  = tx_byte_i;
        end else if (s_q.active) begin
            if (sck_rise_i) begin
                s_d.rx_sh = shifted;
                s_d.cnt   = s_q.cnt + 1'b1;
                if (s_q.cnt == LAST) begin
                    s_d.rx_byte  = shifted;
                    s_d.rx_valid = 1'b1;
                    s_d.rx_first = s_q.first;
                    s_d.first    = 1'b0;
                    s_d.tx_sh    = tx_byte_i;
                    if (s_q.first) s_d.wr_cmd = (shifted == WR_OPC);
                    else           s_d.wr_stb = s_q.wr_cmd & wp_n_i;
                end
            end else if (sck_fall_i && s_q.cnt != '0) begin
                s_d.tx_sh = {s_q.tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign so_o       = s_q.tx_sh[BYTE_W-1];
    assign so_oe_o    = s_q.active;
    assign rx_byte_o  = s_q.rx_byte;
    assign rx_valid_o = s_q.rx_valid;
    assign rx_first_o = s_q.rx_first;
    assign wr_stb_o   = s_q.wr_stb;

    // R2: strobe lasts a single cycle
    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);
    // R5: acceptance only follows a chip-select falling edge
    a_r5_accept_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe_o) |-> $past(cs_fall_i));
    // R6: write strobe rides on a non-opcode byte strobe
    a_r6_wr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (rx_valid_o && !rx_first_o));
    // R7: protect pin low blocks write strobes
    a_r7_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(wp_n_i));
    // R8: inhibit drops the transfer and all strobes
    a_r8_inhibit_drop: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> (!so_oe_o && !rx_valid_o && !wr_stb_o));
endmodule

// File: rtl/spi_target_gate.sv
module spi_target_gate
    import spi_tgt_pkg::*;
#(
    parameter logic [BYTE_W-1:0] WR_OPC = 8'h02,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              si_i,
    input  logic              inhibit_i,
    input  logic              wp_n_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              rx_first_o,
    output logic              wr_stb_o
);
    localparam int unsigned P_SCK = 0;
    localparam int unsigned P_CS  = 1;
    localparam int unsigned P_SI  = 2;
    localparam int unsigned NPINS = 3;

    logic [NPINS-1:0] pins, lvl, rise, fall;

    assign pins[P_SCK] = sck_i;
    assign pins[P_CS]  = csn_i;
    assign pins[P_SI]  = si_i;

    spi_tgt_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    spi_tgt_core #(.WR_OPC(WR_OPC)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_rise_i (rise[P_SCK]),
        .sck_fall_i (fall[P_SCK]),
        .cs_rise_i  (rise[P_CS]),
        .cs_fall_i  (fall[P_CS]),
        .si_i       (lvl[P_SI]),
        .inhibit_i  (inhibit_i),
        .wp_n_i     (wp_n_i),
        .tx_byte_i  (tx_byte_i),
        .so_o       (so_o),
        .so_oe_o    (so_oe_o),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o),
        .rx_first_o (rx_first_o),
        .wr_stb_o   (wr_stb_o)
    );
endmodule

// File: tb/test_spi_target_gate.sv
module test_spi_target_gate;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, si = 1'b0, inhibit = 1'b0, wp_n = 1'b1;
    logic [7:0] tx = 8'h00;
    logic so, so_oe, rx_valid, rx_first, wr_stb;
    logic [7:0] rx_byte;

    int checks = 0, fails = 0;
    int n_valid = 0, n_wr = 0, n_first = 0;
    logic [7:0] bytes_seen [8];

    always #4 clk = ~clk;

    spi_target_gate i_spi_target_gate (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .si_i(si),
        .inhibit_i(inhibit), .wp_n_i(wp_n), .tx_byte_i(tx),
        .so_o(so), .so_oe_o(so_oe), .rx_byte_o(rx_byte),
        .rx_valid_o(rx_valid), .rx_first_o(rx_first), .wr_stb_o(wr_stb)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            if (n_valid < 8) bytes_seen[n_valid] = rx_byte;
            n_valid++;
            if (rx_first) n_first++;
        end
        if (wr_stb) n_wr++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_valid = 0; n_wr = 0; n_first = 0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic cs_down(input logic [7:0] first_tx);
        tx = first_tx;
        csn = 1'b0;
        wait_clk(8);
    endtask

    task automatic cs_up();
        csn = 1'b1;
        wait_clk(8);
    endtask

    // sends nbits of mosi MSB first; if chk, compares so with exp_so before each rise
    task automatic shift_bits(input logic [7:0] mosi, input int nbits,
                              input logic chk, input logic [7:0] exp_so, input string req);
        for (int i = 7; i > 7 - nbits; i--) begin
            si = mosi[i];
            wait_clk(HALF);
            @(negedge clk);
            if (chk) check(req, so, exp_so[i]);
            @(posedge clk);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R4 reset oe", so_oe, 0);
        check("R2 reset valid", rx_valid, 0);
    endtask

    task automatic t_stray_low();
        clear_mon();
        rst_n = 1'b0; csn = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(6);
        shift_bits(8'h03, 8, 1'b0, 8'h00, "");
        shift_bits(8'h55, 8, 1'b0, 8'h00, "");
        @(negedge clk);
        check("R5 stray low no strobe", n_valid, 0);
        check("R5 stray low no oe", so_oe, 0);
        cs_up();
    endtask

    task automatic t_read();
        clear_mon();
        cs_down(8'hA5);
        check("R4 oe on accept", so_oe, 1);
        tx = 8'h3C;
        shift_bits(8'h03, 8, 1'b1, 8'hA5, "R3 first byte so");
        tx = 8'hC3;
        shift_bits(8'h9B, 8, 1'b1, 8'h3C, "R3 reloaded byte so");
        check("R1 opcode byte", bytes_seen[0], 8'h03);
        check("R1 second byte", bytes_seen[1], 8'h9B);
        check("R2 valid count", n_valid, 2);
        check("R2 first count", n_first, 1);
        check("R10 no write on read", n_wr, 0);
        cs_up();
        @(negedge clk);
        check("R4 oe off cs high", so_oe, 0);
    endtask

    task automatic t_write(input logic wp, input int exp_wr, input string req);
        clear_mon();
        wp_n = wp;
        cs_down(8'h00);
        shift_bits(8'h02, 8, 1'b0, 8'h00, "");
        shift_bits(8'h5A, 8, 1'b0, 8'h00, "");
        shift_bits(8'h81, 8, 1'b0, 8'h00, "");
        cs_up();
        check({req, " write strobes"}, n_wr, exp_wr);
        check({req, " byte strobes"}, n_valid, 3);
        check({req, " data byte"}, bytes_seen[2], 8'h81);
        wp_n = 1'b1;
    endtask

    task automatic t_partial();
        clear_mon();
        cs_down(8'h00);
        shift_bits(8'hE0, 3, 1'b0, 8'h00, "");
        cs_up();
        cs_down(8'h00);
        shift_bits(8'h6D, 8, 1'b0, 8'h00, "");
        cs_up();
        check("R9 count after partial", n_valid, 1);
        check("R9 aligned byte", bytes_seen[0], 8'h6D);
    endtask

    task automatic t_inhibit();
        clear_mon();
        cs_down(8'h00);
        shift_bits(8'hF0, 4, 1'b0, 8'h00, "");
        inhibit = 1'b1;
        wait_clk(10);
        @(negedge clk);
        check("R8 oe dropped", so_oe, 0);
        inhibit = 1'b0;
        shift_bits(8'h0F, 4, 1'b0, 8'h00, "");
        shift_bits(8'h02, 8, 1'b0, 8'h00, "");
        check("R8 no strobe after inhibit", n_valid, 0);
        check("R8 oe stays off", so_oe, 0);
        cs_up();
        cs_down(8'h00);
        shift_bits(8'h02, 8, 1'b0, 8'h00, "");
        shift_bits(8'h11, 8, 1'b0, 8'h00, "");
        cs_up();
        check("R8 recovery strobes", n_valid, 2);
        check("R6 write after recovery", n_wr, 1);
    endtask

    initial begin
        fork
            begin
                wait_clk(4);
                rst_n = 1'b1;
                wait_clk(4);
                t_reset();
                t_stray_low();
                t_read();
                t_write(1'b1, 2, "R6");
                t_write(1'b0, 0, "R7");
                t_partial();
                t_inhibit();
            end
            begin
                wait_clk(100000);
                checks++; fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule